// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block is the bus-master side of a synchronous burst that fills one cache line. The cache asks for a line by raising a fill request with the address of the word it needs. The controller accepts the request, raises a burst request and drives the address of the current beat. On every clock where the slave asserts the synchronous termination input, it captures one long word into a line buffer.

The burst always starts at the requested word. It then walks through the line and wraps within the line boundary. The first beat is ended by termination in the same way as a single synchronous cycle. After that, each clock with termination asserted delivers one more beat, and each clock without it is a wait.

A beat counter and a per-word valid mask are exposed, so the cache can write each word as soon as it arrives. The burst request is dropped while the last expected beat is pending, so the slave never delivers a fifth beat. A slave may cut the burst short by asserting burst inhibit together with termination. The controller then finishes with a partial-fill flag, and the cache can invalidate the line or refill it with single cycles.

Top module: `bfill_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block is idle: bus_active, burst_req, fill_done, fill_partial and every word_valid bit are 0.
- R2: fill_ack is high in exactly the idle cycles in which fill_req is high. From the next cycle, bus_active is 1, beat_cnt is 0 and word_valid is all zero.
- R3: A clock where sterm is low while a burst is active captures nothing. beat_cnt, word_valid and bus_addr keep their values, and binh is ignored on such a clock.
- R4: Each clock with bus_active and sterm high stores bus_data into word slot (start + beat_cnt) mod 4 of line_data. Slot k occupies bits [32k+31:32k]. The matching word_valid bit is set and beat_cnt rises by one. Here start is fill_addr[3:2] of the accepted request.
- R5: While active, bus_addr equals fill_addr[31:4] concatenated with the 2-bit slot (start + beat_cnt) mod 4 and 2'b00. The slot wraps from 3 to 0.
- R6: burst_req is high while active with beat_cnt below 3, and low while beat_cnt is 3. After a beat taken with burst_req low, the block is idle.
- R7: After the fourth beat, the block returns to idle. fill_done is high for exactly one cycle with fill_partial low, and word_valid is all ones.
- R8: binh sampled high together with sterm on one of the first three beats captures that beat and ends the burst. fill_done and fill_partial are then both high for one cycle, and word_valid holds only the received words.
- R9: fill_req is ignored while a burst is active: fill_ack stays low and the beat address sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fill_req | input | 1 | Line fill request from the cache |
| fill_addr | input | 32 | Byte address of the word needed first |
| fill_ack | output | 1 | Request accepted this cycle |
| fill_done | output | 1 | One-cycle pulse when the burst ends |
| fill_partial | output | 1 | With fill_done: the slave ended the burst early |
| beat_cnt | output | 3 | Beats received in the current fill |
| word_valid | output | 4 | Per-slot valid mask of the line buffer |
| line_data | output | 128 | Line buffer, slot k in bits [32k+31:32k] |
| burst_req | output | 1 | Burst request to the slave |
| bus_active | output | 1 | A burst transfer is in progress |
| bus_addr | output | 32 | Address of the current beat |
| sterm | input | 1 | Synchronous termination, one beat per asserted clock |
| binh | input | 1 | Burst inhibit, sampled with sterm |
| bus_data | input | 32 | Read data for the current beat |

## Verification
The assertions assume that the slave only asserts sterm while bus_active is high. They also assume that binh matters only on clocks where sterm is high, and that the cache raises fill_req only when it is ready to accept a completion. The stimulus drives sterm and binh only inside an active burst, with random wait clocks between beats. It also raises binh on random wait clocks, where it must have no effect, and issues spurious fill requests only while a burst is running. It releases fill_req before the done cycle, so no request can be accepted in the same cycle as a completion.

// File: rtl/bfill_pkg.sv
package bfill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_BURST = 2'd2
  } bfill_state_e;
endpackage

// File: rtl/bfill_seq.sv
module bfill_seq
  import bfill_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int OFFW  = $clog2(DW / 8),
  localparam int IDXW  = $clog2(WORDS),
  localparam int CW    = $clog2(WORDS + 1),
  localparam int LINEW = OFFW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_req,
  input  logic [AW-1:0]   fill_addr,
  input  logic            sterm,
  input  logic            binh,
  output logic            fill_ack,
  output logic            bus_active,
  output logic            burst_req,
  output logic [AW-1:0]   bus_addr,
  output logic [CW-1:0]   beat_cnt,
  output logic [IDXW-1:0] beat_idx,
  output logic            beat_take,
  output logic            line_clear,
  output logic            fill_done,
  output logic            fill_partial
);
  bfill_state_e          state_q, state_d;
  logic [AW-1:LINEW]     base_q;
  logic [IDXW-1:0]       start_q;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  cnt_en, addr_en;
  logic                  last_beat, finish;
  logic                  done_q, part_q;

  always_comb begin
    fill_ack   = (state_q == ST_IDLE) && fill_req;
    bus_active = (state_q != ST_IDLE);
    last_beat  = (cnt_q == CW'(WORDS - 1));
    burst_req  = bus_active && !last_beat;
    beat_take  = bus_active && sterm;
    finish     = beat_take && (last_beat || binh);
    beat_idx   = IDXW'(start_q + cnt_q[IDXW-1:0]);
    bus_addr   = {base_q, beat_idx, {OFFW{1'b0}}};
    line_clear = fill_ack;
    addr_en    = fill_ack;
    cnt_en     = fill_ack || beat_take;
    cnt_d      = fill_ack ? '0 : CW'(cnt_q + 1'b1);
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:  if (fill_ack) state_d = ST_FIRST;
      ST_FIRST: if (beat_take) state_d = finish ? ST_IDLE : ST_BURST;
      ST_BURST: if (finish) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      done_q  <= finish;
      part_q  <= finish && !last_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
    end else if (addr_en) begin
      base_q  <= fill_addr[AW-1:LINEW];
      start_q <= fill_addr[LINEW-1:OFFW];
    end
  end

  assign beat_cnt     = cnt_q;
  assign fill_done    = done_q;
  assign fill_partial = part_q;

  AST_ACK_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack |=> (bus_active && beat_cnt == '0)); // R2
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> (bus_addr[OFFW-1:0] == '0)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !sterm) |=> $stable(bus_addr)); // R3
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && sterm && !burst_req) |=> !bus_active); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done); // R7
  AST_PARTIAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_partial |-> fill_done); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !fill_done) |=> (bus_active || fill_done)); // R9
endmodule

// File: rtl/bfill_linebuf.sv
module bfill_linebuf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic [IDXW-1:0]    idx,
  input  logic [DW-1:0]      data,
  output logic [WORDS-1:0]   word_valid,
  output logic [WORDS*DW-1:0] line_data
);
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic          wr_en;
    logic          vld_q;
    logic [DW-1:0] dat_q;

    always_comb wr_en = take && (idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else if (clear || wr_en) vld_q <= wr_en;
    end

    always_ff @(posedge clk) begin
      if (wr_en) dat_q <= data;
    end

    assign word_valid[g]           = vld_q;
    assign line_data[g*DW +: DW]   = dat_q;
  end

  AST_WAIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(word_valid)); // R3
  AST_ONE_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> ($countones(word_valid) <= $countones($past(word_valid)) + 1)); // R4
endmodule

// File: rtl/bfill_ctrl.sv
module bfill_ctrl #(
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(WORDS),
  localparam int CW   = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_req,
  input  logic [AW-1:0]      fill_addr,
  output logic               fill_ack,
  output logic               fill_done,
  output logic               fill_partial,
  output logic [CW-1:0]      beat_cnt,
  output logic [WORDS-1:0]   word_valid,
  output logic [WORDS*DW-1:0] line_data,
  output logic               burst_req,
  output logic               bus_active,
  output logic [AW-1:0]      bus_addr,
  input  logic               sterm,
  input  logic               binh,
  input  logic [DW-1:0]      bus_data
);
  logic [1:0]      rst_pipe;
  logic            rst_s;
  logic [IDXW-1:0] beat_idx;
  logic            beat_take;
  logic            line_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  bfill_seq #(.WORDS(WORDS), .AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_s),
    .fill_req     (fill_req),
    .fill_addr    (fill_addr),
    .sterm        (sterm),
    .binh         (binh),
    .fill_ack     (fill_ack),
    .bus_active   (bus_active),
    .burst_req    (burst_req),
    .bus_addr     (bus_addr),
    .beat_cnt     (beat_cnt),
    .beat_idx     (beat_idx),
    .beat_take    (beat_take),
    .line_clear   (line_clear),
    .fill_done    (fill_done),
    .fill_partial (fill_partial)
  );

  bfill_linebuf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_s),
    .clear      (line_clear),
    .take       (beat_take),
    .idx        (beat_idx),
    .data       (bus_data),
    .word_valid (word_valid),
    .line_data  (line_data)
  );

  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_active && sterm) |=> (beat_cnt == CW'($past(beat_cnt) + 1'b1))); // R4
  AST_DONE_ALL_OR_PARTIAL: assert property (@(posedge clk) disable iff (!rst_s)
    (fill_done && !fill_partial) |-> (word_valid == '1)); // R7
endmodule

// File: tb/bfill_ctrl_bench.sv
module bfill_ctrl_bench;
  logic         clk;
  logic         rst_n;
  logic         fill_req;
  logic [31:0]  fill_addr;
  logic         fill_ack, fill_done, fill_partial;
  logic [2:0]   beat_cnt;
  logic [3:0]   word_valid;
  logic [127:0] line_data;
  logic         burst_req, bus_active;
  logic [31:0]  bus_addr;
  logic         sterm, binh;
  logic [31:0]  bus_data;

  int n_checks;
  int n_fails;

  bfill_ctrl u_bfill_ctrl (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_ack(fill_ack), .fill_done(fill_done), .fill_partial(fill_partial),
    .beat_cnt(beat_cnt), .word_valid(word_valid), .line_data(line_data),
    .burst_req(burst_req), .bus_active(bus_active), .bus_addr(bus_addr),
    .sterm(sterm), .binh(binh), .bus_data(bus_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] beat_addr(input logic [31:0] a, input int k);
    logic [1:0] s;
    s = 2'(a[3:2] + 2'(k));
    return {a[31:4], s, 2'b00};
  endfunction

  task automatic run_fill(input logic [31:0] a, input int binh_beat, input int wait_pct);
    logic [31:0] exp_data [4];
    logic [3:0]  exp_valid;
    int          k;
    bit          ended;
    bit          partial;
    exp_valid = '0;
    k = 0;
    ended = 0;
    @(negedge clk);
    fill_req = 1'b1; fill_addr = a; sterm = 1'b0; binh = 1'b0;
    #1 chk(fill_ack == 1'b1, "R2 ack", fill_ack, 1);
    while (!ended) begin
      @(negedge clk);
      chk(bus_active == 1'b1, "R2 active", bus_active, 1);
      chk(beat_cnt == 3'(k), "R4 count", beat_cnt, k);
      chk(word_valid == exp_valid, "R3 valid", word_valid, exp_valid);
      chk(bus_addr == beat_addr(a, k), "R5 addr", bus_addr, beat_addr(a, k));
      chk(burst_req == (k < 3), "R6 burst_req", burst_req, (k < 3));
      fill_req  = ($urandom % 2) == 1;
      fill_addr = $urandom;
      bus_data  = $urandom;
      if (int'($urandom % 100) < wait_pct) begin
        sterm = 1'b0;
        binh  = ($urandom % 2) == 1;
      end else begin
        logic [1:0] idx;
        sterm = 1'b1;
        binh  = (k == binh_beat);
        idx   = 2'(a[3:2] + 2'(k));
        exp_data[idx]  = bus_data;
        exp_valid[idx] = 1'b1;
        ended = (k == 3) || (k == binh_beat);
        k++;
      end
      #1 if (fill_req) chk(fill_ack == 1'b0, "R9 busy ack", fill_ack, 0);
    end
    partial = (binh_beat < 3);
    @(negedge clk);
    fill_req = 1'b0; sterm = 1'b0; binh = 1'b0;
    chk(fill_done == 1'b1, "R7 done", fill_done, 1);
    chk(fill_partial == partial, partial ? "R8 partial" : "R7 partial", fill_partial, partial);
    chk(bus_active == 1'b0, "R7 idle", bus_active, 0);
    chk(word_valid == exp_valid, partial ? "R8 mask" : "R7 mask", word_valid, exp_valid);
    for (int s = 0; s < 4; s++)
      if (exp_valid[s])
        chk(line_data[s*32 +: 32] == exp_data[s], "R4 data", line_data[s*32 +: 32], exp_data[s]);
    @(negedge clk);
    chk(fill_done == 1'b0, "R7 pulse", fill_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0; n_fails = 0;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; fill_req = 1'b0; fill_addr = '0; sterm = 1'b0; binh = 1'b0; bus_data = '0;
    repeat (3) @(negedge clk);
    chk(bus_active == 0 && burst_req == 0 && fill_done == 0 && fill_partial == 0 && word_valid == 0,
        "R1 reset", {bus_active, burst_req, fill_done, fill_partial, word_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_active == 0 && word_valid == 0, "R1 after release", {bus_active, word_valid}, 0);
    run_fill(32'h0000_1000, 9, 0);
    run_fill(32'h0000_20CC, 9, 40);
    run_fill(32'h0000_3008, 0, 20);
    run_fill(32'h0000_4004, 2, 30);
    run_fill(32'h0000_500C, 3, 30);
    for (int i = 0; i < 60; i++)
      run_fill($urandom, (($urandom % 3) == 0) ? int'($urandom % 4) : 9, 30);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule